// File: doc/BRIEF.md
# Operand Addressing Mode Sequencer

This block sits beside the instruction decoder of an 8-bit processor. It gathers the operand bytes that follow an opcode. The decoder gives it a 3-bit addressing mode and the address of the byte after the opcode, then pulses a start strobe. The sequencer reads the bytes it needs from a byte-wide memory with a 16-bit address, one read per cycle. It then reports four things: the operand (an immediate value or a 16-bit effective address), the branch target for relative modes, the number of operand bytes it consumed, and the program counter at which execution continues.

Immediate operands are one byte or two bytes. A two-byte immediate is stored high byte first. A direct-page address is one byte with a zero high byte placed in front of it, so it always lands in 0x0000 to 0x00FF. A relative branch reads a signed 8-bit displacement. It sign-extends the displacement and adds it to the address of the byte that follows the displacement. A combined direct-then-relative mode serves test-and-branch instructions: one byte locates the tested operand and the next byte is the branch displacement. A branch-taken input chooses whether the next program counter is the target or the fall-through address. Opcode decoding and all arithmetic on the operand belong to other blocks.

Top module: `opnd_fetch_seq`

## Requirements
- R1: After reset, done_o, err_o and mem_rd_o are low, and result_o, target_o, next_pc_o and nbytes_o are zero.
- R2: Mode 0 (no operand) issues no memory read. It completes with nbytes_o = 0, next_pc_o = pc_i, and result_o = target_o = 0.
- R3: Mode 1 (one-byte immediate) reads the address pc_i. It completes with result_o = {0x00, byte}, nbytes_o = 1, next_pc_o = pc_i + 1 and target_o = 0.
- R4: Mode 2 (two-byte immediate) reads pc_i and then pc_i + 1 in back-to-back cycles. It completes with result_o = {byte at pc_i, byte at pc_i + 1}, nbytes_o = 2, next_pc_o = pc_i + 2 and target_o = 0.
- R5: Mode 3 (direct page) reads pc_i. It completes with result_o = {0x00, byte}, nbytes_o = 1, next_pc_o = pc_i + 1 and target_o = 0.
- R6: Mode 4 (relative) reads a displacement d at pc_i. It completes with target_o = (pc_i + 1 + sign-extended d) mod 65536, result_o = 0 and nbytes_o = 1. next_pc_o is target_o when taken_i = 1 and pc_i + 1 otherwise.
- R7: Mode 5 (direct then relative) reads a page byte a at pc_i and a displacement d at pc_i + 1. It completes with result_o = {0x00, a}, target_o = (pc_i + 2 + sign-extended d) mod 65536 and nbytes_o = 2. next_pc_o is target_o when taken_i = 1 and pc_i + 2 otherwise.
- R8: Modes 6 and 7 issue no read. They complete with err_o = 1, nbytes_o = 0, next_pc_o = pc_i and result_o = target_o = 0. err_o is low on every other completion.
- R9: mem_rd_o marks each read, and its data is taken from mem_rdata_i one cycle later. Count the edge that samples start_i as edge 0. done_o is a one-cycle pulse in the cycle after edge 0 for zero-byte modes, and in the cycle after edge n+1 for n-byte modes. The outputs hold their values until the next completion. taken_i is sampled at the edge that captures the last operand byte.
- R10: A start_i pulse that arrives while an operation is in flight is ignored. The running operation completes unchanged, and no extra completion follows.
- R11: Read addresses and all sums wrap modulo 65536. A two-byte fetch at 0xFFFF reads 0xFFFF and then 0x0000, and gives next_pc_o = 0x0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; sampled only when idle |
| mode_i | input | 3 | Addressing mode code (0..5 valid) |
| pc_i | input | 16 | Address of the byte after the opcode |
| taken_i | input | 1 | Branch condition for the relative modes |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 16 | Memory read address |
| mem_rdata_i | input | 8 | Read data, valid one cycle after the strobe |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Unused mode code at completion |
| result_o | output | 16 | Immediate value or effective address |
| target_o | output | 16 | Relative branch target |
| nbytes_o | output | 2 | Operand bytes consumed |
| next_pc_o | output | 16 | Program counter after the operands |

## Verification
The checker watches the timing skeleton on every cycle. It checks that done is a single-cycle pulse that follows each internal finish event. It checks that a byte is captured only in the cycle after its read, that reads in consecutive cycles step the address by one (with wrap), that no read overlaps a completion, and that an error completion carries no bytes and no result. The values themselves can only be shown by the bench's scenarios: the high-byte-first immediate, the zero-page prefix, sign extension of the displacement from the correct base, the choice between taken and fall-through, and an ignored start during a busy operation. The bench sweeps every mode code with both branch settings over a range of start addresses, including the top of the address space.

// File: rtl/opnd_fetch_pkg.sv
package opnd_fetch_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int MODE_W = 3;
  localparam int CNT_W  = 2;
  localparam int PAD_W  = ADDR_W - DATA_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [MODE_W-1:0] mode_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  typedef enum logic [MODE_W-1:0] {
    AM_NONE    = 3'd0,
    AM_IMM1    = 3'd1,
    AM_IMM2    = 3'd2,
    AM_PAGE    = 3'd3,
    AM_BRANCH  = 3'd4,
    AM_PAGE_BR = 3'd5
  } amode_e;

  typedef struct packed {
    addr_t result;
    addr_t target;
    addr_t next_pc;
    cnt_t  nbytes;
    logic  err;
  } outcome_t;

  // Operand bytes that follow the opcode for a given mode code.
  function automatic cnt_t bytes_for(mode_t m);
    case (m)
      AM_IMM1, AM_PAGE, AM_BRANCH: bytes_for = cnt_t'(1);
      AM_IMM2, AM_PAGE_BR:         bytes_for = cnt_t'(2);
      default:                     bytes_for = cnt_t'(0);
    endcase
  endfunction

  function automatic logic mode_known(mode_t m);
    mode_known = (m <= mode_t'(AM_PAGE_BR));
  endfunction

  // Zero high byte in front of a page byte.
  function automatic addr_t page_addr(byte_t b);
    page_addr = {{PAD_W{1'b0}}, b};
  endfunction

  // Sign-extend a displacement and add it to a base, wrapping.
  function automatic addr_t branch_sum(addr_t base, byte_t disp);
    branch_sum = base + {{PAD_W{disp[DATA_W-1]}}, disp};
  endfunction

  // Final results from the mode, start address and fetched bytes.
  function automatic outcome_t resolve(mode_t m, addr_t pc, byte_t b0,
                                       byte_t b1, logic taken);
    outcome_t o;
    addr_t    fall;
    o        = '0;
    o.next_pc = pc;
    o.nbytes  = bytes_for(m);
    fall      = pc + addr_t'(bytes_for(m));
    case (m)
      AM_NONE: ;
      AM_IMM1: begin
        o.result  = page_addr(b0);
        o.next_pc = fall;
      end
      AM_IMM2: begin
        o.result  = {b0, b1};
        o.next_pc = fall;
      end
      AM_PAGE: begin
        o.result  = page_addr(b0);
        o.next_pc = fall;
      end
      AM_BRANCH: begin
        o.target  = branch_sum(fall, b0);
        o.next_pc = taken ? o.target : fall;
      end
      AM_PAGE_BR: begin
        o.result  = page_addr(b0);
        o.target  = branch_sum(fall, b1);
        o.next_pc = taken ? o.target : fall;
      end
      default: o.err = 1'b1;
    endcase
    resolve = o;
  endfunction

endpackage

// File: rtl/opnd_fetch_ctrl.sv
module opnd_fetch_ctrl
  import opnd_fetch_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  input  mode_t mode_i,
  input  addr_t pc_i,
  output logic  issue_ev,
  output addr_t issue_addr,
  output logic  capture_ev,
  output cnt_t  capture_idx,
  output logic  finish_ev,
  output mode_t fin_mode,
  output addr_t fin_pc
);

  logic  busy_q;
  mode_t mode_q;
  addr_t pc_q;
  cnt_t  need_q;
  cnt_t  iss_q;
  cnt_t  rcv_q;
  logic  pend_q;

  logic  accept;
  cnt_t  need_now;
  logic  zero_finish;
  logic  last_capture;

  assign accept       = start_i && !busy_q;
  assign need_now     = bytes_for(mode_i);
  assign zero_finish  = accept && (need_now == cnt_t'(0));
  assign issue_ev     = busy_q && (iss_q < need_q);
  assign issue_addr   = pc_q + addr_t'(iss_q);
  assign capture_ev   = pend_q;
  assign capture_idx  = rcv_q;
  assign last_capture = capture_ev && ((rcv_q + cnt_t'(1)) == need_q);
  assign finish_ev    = zero_finish || last_capture;
  assign fin_mode     = last_capture ? mode_q : mode_i;
  assign fin_pc       = last_capture ? pc_q : pc_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mode_q <= '0;
      pc_q   <= '0;
      need_q <= '0;
      iss_q  <= '0;
      rcv_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= issue_ev;
      if (accept) begin
        busy_q <= (need_now != cnt_t'(0));
        mode_q <= mode_i;
        pc_q   <= pc_i;
        need_q <= need_now;
        iss_q  <= '0;
        rcv_q  <= '0;
      end else begin
        if (issue_ev) iss_q <= iss_q + cnt_t'(1);
        if (capture_ev) rcv_q <= rcv_q + cnt_t'(1);
        if (last_capture) busy_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/opnd_fetch_bytes.sv
module opnd_fetch_bytes
  import opnd_fetch_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  capture_ev,
  input  cnt_t  capture_idx,
  input  byte_t rdata,
  output byte_t byte0,
  output byte_t byte1
);

  byte_t first_q;
  logic  at_first;

  assign at_first = (capture_idx == cnt_t'(0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) first_q <= '0;
    else if (capture_ev && at_first) first_q <= rdata;
  end

  // The newest byte is read straight from the bus so the result is
  // ready at the edge that captures it.
  assign byte0 = at_first ? rdata : first_q;
  assign byte1 = rdata;

endmodule

// File: rtl/opnd_fetch_calc.sv
module opnd_fetch_calc
  import opnd_fetch_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  finish_ev,
  input  mode_t fin_mode,
  input  addr_t fin_pc,
  input  byte_t byte0,
  input  byte_t byte1,
  input  logic  taken_i,
  output logic  done_o,
  output logic  err_o,
  output addr_t result_o,
  output addr_t target_o,
  output cnt_t  nbytes_o,
  output addr_t next_pc_o
);

  outcome_t calc;
  outcome_t held_q;

  assign calc = resolve(fin_mode, fin_pc, byte0, byte1, taken_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      held_q <= '0;
    end else begin
      done_o <= finish_ev;
      if (finish_ev) held_q <= calc;
    end
  end

  assign err_o     = held_q.err;
  assign result_o  = held_q.result;
  assign target_o  = held_q.target;
  assign nbytes_o  = held_q.nbytes;
  assign next_pc_o = held_q.next_pc;

endmodule

// File: rtl/opnd_fetch_seq.sv
module opnd_fetch_seq
  import opnd_fetch_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [2:0]  mode_i,
  input  logic [15:0] pc_i,
  input  logic        taken_i,
  output logic        mem_rd_o,
  output logic [15:0] mem_addr_o,
  input  logic [7:0]  mem_rdata_i,
  output logic        done_o,
  output logic        err_o,
  output logic [15:0] result_o,
  output logic [15:0] target_o,
  output logic [1:0]  nbytes_o,
  output logic [15:0] next_pc_o
);

  // Internal events, named for the checker.
  logic  issue_ev;
  logic  capture_ev;
  logic  finish_ev;
  addr_t issue_addr;
  cnt_t  capture_idx;
  mode_t fin_mode;
  addr_t fin_pc;
  byte_t byte0;
  byte_t byte1;

  opnd_fetch_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .pc_i        (pc_i),
    .issue_ev    (issue_ev),
    .issue_addr  (issue_addr),
    .capture_ev  (capture_ev),
    .capture_idx (capture_idx),
    .finish_ev   (finish_ev),
    .fin_mode    (fin_mode),
    .fin_pc      (fin_pc)
  );

  opnd_fetch_bytes u_bytes (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture_ev  (capture_ev),
    .capture_idx (capture_idx),
    .rdata       (mem_rdata_i),
    .byte0       (byte0),
    .byte1       (byte1)
  );

  opnd_fetch_calc u_calc (
    .clk       (clk),
    .rst_n     (rst_n),
    .finish_ev (finish_ev),
    .fin_mode  (fin_mode),
    .fin_pc    (fin_pc),
    .byte0     (byte0),
    .byte1     (byte1),
    .taken_i   (taken_i),
    .done_o    (done_o),
    .err_o     (err_o),
    .result_o  (result_o),
    .target_o  (target_o),
    .nbytes_o  (nbytes_o),
    .next_pc_o (next_pc_o)
  );

  assign mem_rd_o   = issue_ev;
  assign mem_addr_o = issue_ev ? issue_addr : '0;

endmodule

// File: rtl/opnd_fetch_chk.sv
module opnd_fetch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_rd_o,
  input logic [15:0] mem_addr_o,
  input logic        done_o,
  input logic        err_o,
  input logic [15:0] result_o,
  input logic [15:0] target_o,
  input logic [1:0]  nbytes_o,
  input logic        issue_ev,
  input logic        capture_ev,
  input logic        finish_ev
);

  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: every internal finish is reported on done_o one cycle later
  assert_finish_reported_R9: assert property (@(posedge clk) disable iff (!rst_n)
    finish_ev |=> done_o);

  // R9: a byte is taken only in the cycle after its read
  assert_capture_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    capture_ev |-> $past(issue_ev));

  // R9: no read overlaps a completion cycle
  assert_no_read_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> !done_o);

  // R4, R11: reads in consecutive cycles step the address by one, wrapping
  assert_addr_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && $past(mem_rd_o)) |-> (mem_addr_o == $past(mem_addr_o) + 16'd1));

  // R8: an error completion consumes nothing and returns no operand
  assert_err_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> (nbytes_o == 2'd0 && result_o == 16'd0 && target_o == 16'd0));

endmodule

bind opnd_fetch_seq opnd_fetch_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_rd_o   (mem_rd_o),
  .mem_addr_o (mem_addr_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .result_o   (result_o),
  .target_o   (target_o),
  .nbytes_o   (nbytes_o),
  .issue_ev   (issue_ev),
  .capture_ev (capture_ev),
  .finish_ev  (finish_ev)
);

// File: tb/opnd_fetch_seq_test.sv
`timescale 1ns/1ps
module opnd_fetch_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic [15:0] pc_i = 16'd0;
  logic        taken_i = 1'b0;
  logic        mem_rd_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_rdata_i = 8'd0;
  logic        done_o;
  logic        err_o;
  logic [15:0] result_o;
  logic [15:0] target_o;
  logic [1:0]  nbytes_o;
  logic [15:0] next_pc_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int rd_cnt = 0;
  logic [15:0] first_addr = 16'd0;
  logic [15:0] last_addr = 16'd0;
  logic seq_bad = 1'b0;

  always #5 clk = ~clk;

  opnd_fetch_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .pc_i(pc_i), .taken_i(taken_i), .mem_rd_o(mem_rd_o),
    .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i), .done_o(done_o),
    .err_o(err_o), .result_o(result_o), .target_o(target_o),
    .nbytes_o(nbytes_o), .next_pc_o(next_pc_o)
  );

  function automatic logic [7:0] memf(logic [15:0] a);
    logic [7:0] hi;
    hi = a[15:8];
    return a[7:0] ^ (hi * 8'd3) ^ 8'h5C;
  endfunction

  // Memory model: data appears the cycle after the read strobe.
  always @(posedge clk) begin
    if (mem_rd_o) begin
      mem_rdata_i <= memf(mem_addr_o);
      if (rd_cnt == 0) first_addr = mem_addr_o;
      else if (mem_addr_o != last_addr + 16'd1) seq_bad = 1'b1;
      last_addr = mem_addr_o;
      rd_cnt = rd_cnt + 1;
    end
  end

  task automatic chk(input logic ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Runs one operation; poke drives a second start while busy (R10).
  task automatic run_op(input logic [2:0] m, input logic [15:0] p,
                        input logic t, input logic poke);
    int need, lat, lat_exp;
    logic [7:0] b0, b1;
    logic [15:0] e_res, e_tgt, e_npc, fall;
    logic e_err;
    string tg;
    tg = tag_of(m);
    need = (m == 3'd1 || m == 3'd3 || m == 3'd4) ? 1 :
           (m == 3'd2 || m == 3'd5) ? 2 : 0;
    lat_exp = (need == 0) ? 1 : need + 2;
    @(negedge clk);
    rd_cnt = 0; seq_bad = 1'b0;
    start_i = 1'b1; mode_i = m; pc_i = p; taken_i = t;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    if (poke && need > 0) begin
      start_i = 1'b1; mode_i = 3'd0; pc_i = 16'h1234;
    end
    while (!done_o && lat < 20) begin
      @(negedge clk);
      lat++;
      start_i = 1'b0;
    end
    b0 = memf(p);
    b1 = memf(p + 16'd1);
    fall = p + 16'(need);
    e_res = 16'd0; e_tgt = 16'd0; e_npc = p; e_err = 1'b0;
    case (m)
      3'd1, 3'd3: begin e_res = {8'h00, b0}; e_npc = fall; end
      3'd2: begin e_res = {b0, b1}; e_npc = fall; end
      3'd4: begin
        e_tgt = fall + 16'($signed(b0));
        e_npc = t ? e_tgt : fall;
      end
      3'd5: begin
        e_res = {8'h00, b0};
        e_tgt = fall + 16'($signed(b1));
        e_npc = t ? e_tgt : fall;
      end
      3'd6, 3'd7: e_err = 1'b1;
      default: ;
    endcase
    chk(lat == lat_exp, "R9", "latency", lat, lat_exp);
    chk(result_o == e_res, tg, "result", result_o, e_res);
    chk(target_o == e_tgt, tg, "target", target_o, e_tgt);
    chk(next_pc_o == e_npc, tg, "next_pc", next_pc_o, e_npc);
    chk(int'(nbytes_o) == need, tg, "nbytes", nbytes_o, need);
    chk(err_o == e_err, "R8", "err", err_o, e_err);
    chk(rd_cnt == need, tg, "read count", rd_cnt, need);
    if (need > 0) begin
      chk(first_addr == p, tg, "first read addr", first_addr, p);
      chk(!seq_bad, "R11", "read sequence", seq_bad, 0);
    end
    @(negedge clk);
    chk(!done_o, "R9", "done pulse width", done_o, 0);
    chk(result_o == e_res && next_pc_o == e_npc, "R9", "hold after done",
        next_pc_o, e_npc);
    if (poke) begin
      repeat (3) begin
        @(negedge clk);
        chk(!done_o, "R10", "no extra completion", done_o, 0);
      end
      chk(next_pc_o == e_npc, "R10", "busy start ignored", next_pc_o, e_npc);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!done_o && !err_o && !mem_rd_o, "R1", "reset strobes", done_o, 0);
    chk(result_o == 0 && target_o == 0, "R1", "reset result", result_o, 0);
    chk(next_pc_o == 0 && nbytes_o == 0, "R1", "reset pc", next_pc_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_rd_o && !done_o, "R1", "idle after reset", mem_rd_o, 0);

    // Sweep: every mode code, both branch settings, a range of addresses.
    for (int p = 0; p < 272; p++)
      for (int m = 0; m < 8; m++)
        for (int t = 0; t < 2; t++)
          run_op(3'(m), 16'(p), 1'(t), 1'b0);
    for (int p = 16'hFFF0; p <= 16'hFFFF; p++)
      for (int m = 0; m < 8; m++)
        for (int t = 0; t < 2; t++)
          run_op(3'(m), 16'(p), 1'(t), 1'b0);
    for (int p = 16'h7F78; p < 16'h7F88; p++)
      for (int m = 0; m < 8; m++)
        for (int t = 0; t < 2; t++)
          run_op(3'(m), 16'(p), 1'(t), 1'b0);

    // R11: two-byte fetch across the top of the address space
    run_op(3'd2, 16'hFFFF, 1'b0, 1'b0);
    chk(first_addr == 16'hFFFF && last_addr == 16'h0000, "R11", "wrap reads",
        last_addr, 0);
    chk(next_pc_o == 16'h0001, "R11", "wrap next_pc", next_pc_o, 1);

    // R10: start while busy, each fetching mode
    for (int m = 1; m < 6; m++) begin
      run_op(3'(m), 16'h0140, 1'b1, 1'b1);
      run_op(3'(m), 16'h00F7, 1'b0, 1'b1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule